// File: doc/BRIEF.md
# Selectable Sine and Square Waveform Generator

The block emits one signed 8-bit sample on every rising clock edge. A single phase counter runs freely and serves both waveforms. In square mode the sample is one of two fixed codes, depending on whether the phase is below a threshold. In sine mode the phase addresses a 256-entry table of signed sine samples covering exactly one period. The table contents come from a function evaluated at elaboration, and are not typed in as literals.

The reset input is active low and asserts asynchronously. It presets a four-stage shift chain to all ones. Each clock then shifts a zero in from the top, and the bottom stage acts as a local synchronous reset for the counter and the output register. The output frequency is the clock frequency divided by the sequence length. The length is 256 by default, and a period parameter can shorten it so that the counter wraps at PERIOD-1.

Top module: `wave_synth`

## Requirements
- R1: While the reset input is low the output is 0. After the reset input rises, the output stays 0 for the first four rising edges. The fifth edge loads the sample for phase 0.
- R2: When the reset input falls at any time, even between edges, the output is 0 from the next rising edge on. After the next release the sequence restarts at phase 0, with the same four-edge delay as R1.
- R3: With the select input at 0 (square), the sample is -127 (8'h81) when the phase is below THRESH, and +127 (8'h7F) when the phase is at or above THRESH. THRESH defaults to PERIOD/2.
- R4: With the select input at 1 (sine), the sample is round(127*sin(2*pi*p/256)) for phase p. This gives 0 at p=0, +127 at p=64 and -127 at p=192, and the value -128 never appears.
- R5: The phase advances by one per edge and wraps from PERIOD-1 to 0 (255 to 0 by default). The output sequence therefore repeats every PERIOD samples.
- R6: The output is registered. The sample seen after an edge belongs to the phase held before that edge, and each successive sample belongs to the next phase.
- R7: Both waveforms share one counter. A change of the select input takes effect on the sample loaded at the next edge, and it neither resets nor skips the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| waveSel | input | 1 | 0 selects square, 1 selects sine |
| sampleOut | output | 8 | Signed sample stream |

## Verification
The select change and the counter wrap can fall on the same edge. So can the reset chain release and the loading of the first sample. The bench toggles the select input on an irregular pattern that lands on wrap edges of both a full-length and a 10-sample instance. Each such sample must equal the newly chosen waveform at the wrapped phase 0. The bench also asserts reset between edges in the middle of a sweep, and it judges the restart by requiring exactly four zero samples followed by phase 0.

// File: rtl/wave_pkg.sv
`timescale 1ns/1ps
package wave_pkg;
  localparam int SAMPLE_W = 8;
  localparam int TABLE_AW = 8;
  localparam int TABLE_DEPTH = 2 ** TABLE_AW;
  localparam int QTR = TABLE_DEPTH / 4;
  localparam int AMP = 2 ** (SAMPLE_W - 1) - 1;
  localparam int FRAC = 28;
  localparam longint ONE_Q = longint'(1) << FRAC;
  localparam longint PI_Q = 64'd843314857;

  typedef struct packed {
    logic clear;
    logic wrap;
  } ctrlStrobe_t;

  // Fixed-point Taylor series on a quarter wave, mirrored by quadrant.
  function automatic logic signed [SAMPLE_W-1:0] sineAt(input int idx);
    int quad;
    int offs;
    int j;
    longint x;
    longint term;
    longint sum;
    longint mag;
    quad = (idx / QTR) % 4;
    offs = idx % QTR;
    j = (quad == 1 || quad == 3) ? (QTR - offs) : offs;
    x = (PI_Q * longint'(j)) / longint'(2 * QTR);
    term = x;
    sum = x;
    for (int k = 1; k <= 7; k++) begin
      term = -(((term * x) / ONE_Q) * x / ONE_Q) / longint'((2 * k) * (2 * k + 1));
      sum = sum + term;
    end
    if (sum < 0) sum = 0;
    mag = (longint'(AMP) * sum + ONE_Q / 2) / ONE_Q;
    if (quad >= 2) mag = -mag;
    return SAMPLE_W'(mag);
  endfunction
endpackage

// File: rtl/wave_ctrl.sv
`timescale 1ns/1ps
module wave_ctrl
  import wave_pkg::*;
#(
  parameter int PERIOD = TABLE_DEPTH,
  parameter int RST_STAGES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  output ctrlStrobe_t         strobe,
  output logic [TABLE_AW-1:0] phase
);
  localparam logic [TABLE_AW-1:0] LAST = TABLE_AW'(PERIOD - 1);

  logic [RST_STAGES-1:0] rstChain;
  logic localRst;
  logic atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstChain <= '1;
    else       rstChain <= {1'b0, rstChain[RST_STAGES-1:1]};
  end

  assign localRst = rstChain[0];
  assign atLast = (phase == LAST);

  always_ff @(posedge clk) begin
    if (localRst)    phase <= '0;
    else if (atLast) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  assign strobe.clear = localRst;
  assign strobe.wrap = atLast;

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> phase == '0); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.wrap) |=> phase == $past(phase) + 1'b1); // R5
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.wrap) |=> phase == '0); // R5
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |-> int'(phase) < PERIOD); // R5
endmodule

// File: rtl/wave_dpath.sv
`timescale 1ns/1ps
module wave_dpath
  import wave_pkg::*;
#(
  parameter int THRESH = TABLE_DEPTH / 2,
  parameter int SQ_LOW = -AMP,
  parameter int SQ_HIGH = AMP
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [TABLE_AW-1:0]        phase,
  input  logic                       waveSel,
  output logic signed [SAMPLE_W-1:0] sampleOut
);
  localparam logic signed [SAMPLE_W-1:0] LOW_CODE = SAMPLE_W'(SQ_LOW);
  localparam logic signed [SAMPLE_W-1:0] HIGH_CODE = SAMPLE_W'(SQ_HIGH);
  localparam logic [TABLE_AW:0] THR = (TABLE_AW + 1)'(THRESH);

  logic signed [SAMPLE_W-1:0] sineRom [TABLE_DEPTH];
  logic signed [SAMPLE_W-1:0] squareVal;
  logic signed [SAMPLE_W-1:0] nextSample;

  for (genvar g = 0; g < TABLE_DEPTH; g++) begin : g_rom
    assign sineRom[g] = sineAt(g);
  end

  assign squareVal = ({1'b0, phase} < THR) ? LOW_CODE : HIGH_CODE;
  assign nextSample = waveSel ? sineRom[phase] : squareVal;

  always_ff @(posedge clk) begin
    if (strobe.clear) sampleOut <= '0;
    else              sampleOut <= nextSample;
  end

  AST_OUT_ZERO_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> sampleOut == '0); // R1
  AST_SQUARE_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !waveSel) |=> (sampleOut == LOW_CODE || sampleOut == HIGH_CODE)); // R3
  AST_SINE_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && waveSel) |=> sampleOut != {1'b1, {(SAMPLE_W-1){1'b0}}}); // R4
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.wrap) |=> phase == '0); // R5
endmodule

// File: rtl/wave_synth.sv
`timescale 1ns/1ps
module wave_synth
  import wave_pkg::*;
#(
  parameter int PERIOD = TABLE_DEPTH,
  parameter int THRESH = PERIOD / 2,
  parameter int SQ_LOW = -AMP,
  parameter int SQ_HIGH = AMP
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       waveSel,
  output logic signed [SAMPLE_W-1:0] sampleOut
);
  ctrlStrobe_t strobe;
  logic [TABLE_AW-1:0] phase;

  wave_ctrl #(.PERIOD(PERIOD), .RST_STAGES(4)) i_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phase(phase)
  );

  wave_dpath #(.THRESH(THRESH), .SQ_LOW(SQ_LOW), .SQ_HIGH(SQ_HIGH)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phase(phase),
    .waveSel(waveSel), .sampleOut(sampleOut)
  );
endmodule

// File: tb/test_wave_synth.sv
`timescale 1ns/1ps
module test_wave_synth;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic waveSel = 1'b0;
  logic signed [7:0] outLong;
  logic signed [7:0] outShort;
  int nChecks = 0;
  int nFail = 0;
  int idx = 0;
  localparam int SHORT_P = 10;
  localparam int SHORT_T = 3;

  always #2.5 clk = ~clk;

  wave_synth i_wave_synth (.clk(clk), .rstN(rstN), .waveSel(waveSel), .sampleOut(outLong));
  wave_synth #(.PERIOD(SHORT_P), .THRESH(SHORT_T)) i_wave_synth_short (
    .clk(clk), .rstN(rstN), .waveSel(waveSel), .sampleOut(outShort));

  function automatic int sineRef(int p);
    real v;
    v = 127.0 * $sin(2.0 * 3.141592653589793 * p / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int waveRef(logic s, int p, int thr);
    if (s) return sineRef(p);
    return (p < thr) ? -127 : 127;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic checkBoth(string req);
    check(req, int'(outLong), waveRef(waveSel, idx % 256, 128));
    check(req, int'(outShort), waveRef(waveSel, idx % SHORT_P, SHORT_T));
  endtask

  initial begin
    #(5.0 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    check("R1", int'(outLong), 0);
    check("R1", int'(outShort), 0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R1", int'(outLong), 0);
      check("R1", int'(outShort), 0);
    end
    // R4 and R5: full sine sweep, beyond one wrap
    waveSel = 1'b1;
    idx = 0;
    for (int i = 0; i < 266; i++) begin
      tick();
      checkBoth(idx < 256 ? "R4" : "R5");
      idx++;
    end
    // R3: full square sweep
    waveSel = 1'b0;
    for (int i = 0; i < 256; i++) begin
      tick();
      checkBoth("R3");
      idx++;
    end
    // R6 and R7: irregular select toggling, crossing wrap edges
    for (int i = 0; i < 300; i++) begin
      waveSel = ((i * 7) % 5) < 2;
      tick();
      checkBoth("R7");
      idx++;
    end
    // R2: reset asserted between edges mid-run
    waveSel = 1'b1;
    #1 rstN = 1'b0;
    tick();
    check("R2", int'(outLong), 0);
    check("R2", int'(outShort), 0);
    tick();
    check("R2", int'(outLong), 0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R2", int'(outLong), 0);
      check("R2", int'(outShort), 0);
    end
    idx = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      checkBoth(i == 0 ? "R2" : "R6");
      idx++;
    end
    finishRun();
  end
endmodule